// File: doc/BRIEF.md
# Over-Temperature Fan Override

This block sits between a fan-curve controller and the PWM waveform generators. It compares the temperature of each of several zones against that zone's thermal limit. When any zone runs too hot, it replaces the normal duty command on every fan channel with a boost level. The boost level is either full duty or a per-channel ceiling held in a register. A zone that has tripped stays in the override state until its temperature falls below the limit minus a programmable hysteresis band. A configuration input can turn that hold off, so the zone then releases as soon as it is back below the limit.

A separate thermal output pin follows one selected zone. The pin is set when that zone goes one quarter degree or more above its limit. By default it then stays set until it is acknowledged. A configuration input turns the pin into a live, non-latching indication instead.

Temperatures are unsigned 10-bit codes in quarter-degree steps, with code = (°C + 64) × 4. Limits are 8-bit whole-degree codes, with code = °C + 64. Hysteresis values are whole degrees. Typical reset values programmed by the surrounding register file are a 4 °C hysteresis, a 100 °C limit (code 164) for the first remote zone and a 136 °C limit (code 200) for the second. Every output is registered, and the block has one cycle of latency.

Top module: `ot_fan_override`

## Requirements
- R1: A zone enters the override state when its temperature code is strictly greater than its limit code × 4. A temperature equal to limit × 4 does not start an event.
- R2: With the hysteresis hold enabled (`cfg_hold_off_i` = 0), a tripped zone stays tripped while its temperature is at or above (limit − hysteresis) × 4. It releases once the temperature is below that threshold.
- R3: With `cfg_hold_off_i` = 1, a tripped zone stays tripped while its temperature is at or above limit × 4. It releases once the temperature is below limit × 4.
- R4: When the hysteresis exceeds the limit, the release threshold saturates at code 0. A tripped zone then stays tripped in hold mode even at temperature code 0.
- R5: While any zone is tripped and `cfg_use_max_i` = 0, every channel of `duty_o` is all ones (full duty).
- R6: While any zone is tripped and `cfg_use_max_i` = 1, channel c of `duty_o` equals channel c of `duty_max_i`.
- R7: While no zone is tripped, channel c of `duty_o` equals channel c of `duty_req_i` from the previous cycle.
- R8: Bit z of `ot_status_o` is the live tripped state of zone z. It is not sticky and clears when the zone releases.
- R9: `therm_o` rises when the zone indexed by `therm_sel_i` is above its limit × 4. Indices 0 to NZONE−1 select a zone; any larger index selects none.
- R10: With `cfg_latch_off_i` = 0, `therm_o` stays high after its condition goes away, until a cycle with `therm_ack_i` = 1 and the condition absent. An acknowledge while the condition is present has no effect.
- R11: With `cfg_latch_off_i` = 1, `therm_o` follows the selected zone's above-limit condition cycle by cycle.
- R12: During reset, `ot_status_o`, `therm_o` and every channel of `duty_o` are 0.
- R13: Inputs sampled at a clock edge show on the outputs right after that edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | NZONE×10 | Zone temperatures, quarter-degree codes |
| lim_i | input | NZONE×8 | Zone thermal limits, whole-degree codes |
| hyst_i | input | NZONE×8 | Zone hysteresis, whole degrees |
| cfg_hold_off_i | input | 1 | 1: release at the limit, no hysteresis hold |
| cfg_use_max_i | input | 1 | 1: boost to per-channel ceiling instead of full duty |
| duty_max_i | input | NCH×8 | Per-channel boost ceiling |
| duty_req_i | input | NCH×8 | Normal duty commands |
| therm_sel_i | input | 2 | Zone index driving the thermal pin |
| cfg_latch_off_i | input | 1 | 1: thermal pin is live, not latched |
| therm_ack_i | input | 1 | Clears a latched thermal pin once the condition is gone |
| duty_o | output | NCH×8 | Final duty commands |
| ot_status_o | output | NZONE | Live per-zone override state |
| therm_o | output | 1 | Thermal output pin, active high |

## Verification
The assertions assume that every input is stable over a whole clock cycle. They also assume that the hysteresis field is no wider than the limit field, so the quarter-degree threshold fits the temperature width. The stimulus changes inputs only on the falling edge. It keeps temperatures within the 10-bit code range by clamping values drawn around each zone's limit. It draws hysteresis values from a small range, which still lets some cases exceed very low limits. The acknowledge is a one-cycle pulse, dropped at the next falling edge.

// File: rtl/ot_pkg.sv
package ot_pkg;
    // Quarter-degree resolution below each whole degree.
    localparam int unsigned FRAC_BITS = 2;

    typedef struct packed {
        logic act;
    } zone_st_t;

    typedef struct packed {
        logic pin;
    } therm_st_t;
endpackage

// File: rtl/ot_zone_track.sv
module ot_zone_track
    import ot_pkg::*;
#(
    parameter int LW = 8,
    parameter int HW = 8,
    localparam int TW = LW + FRAC_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp_i,
    input  logic [LW-1:0] lim_i,
    input  logic [HW-1:0] hyst_i,
    input  logic          hold_off_i,
    output logic          above_o,
    output logic          act_nxt_o,
    output logic          act_o
);
    zone_st_t      st_d, st_q;
    logic [TW-1:0] lim_full;
    logic [TW-1:0] hyst_full;
    logic [TW-1:0] rel_thr;
    logic          drop;

    always_comb begin
        lim_full  = {lim_i, {FRAC_BITS{1'b0}}};
        hyst_full = TW'({hyst_i, {FRAC_BITS{1'b0}}});
        rel_thr   = (hyst_full > lim_full) ? '0 : (lim_full - hyst_full);
        above_o   = temp_i > lim_full;
        drop      = hold_off_i ? (temp_i < lim_full) : (temp_i < rel_thr);
        st_d      = st_q;
        st_d.act  = above_o | (st_q.act & ~drop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o     = st_q.act;
    assign act_nxt_o = st_d.act;

    // R1: an event only begins after a sample above the limit
    assert_trip_above_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.act) |-> $past(temp_i > lim_full));
    // R3: no release while the temperature sits at or above the limit
    assert_release_below_lim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.act) |-> $past(temp_i < lim_full));
    // R2: in hold mode the release needs the hysteresis band cleared
    assert_release_band_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.act) && !$past(hold_off_i)) |-> $past(temp_i < rel_thr));
endmodule

// File: rtl/ot_duty_sel.sv
module ot_duty_sel #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ovr_nxt_i,
    input  logic          use_max_i,
    input  logic [DW-1:0] max_i,
    input  logic [DW-1:0] req_i,
    output logic [DW-1:0] duty_o
);
    typedef struct packed {
        logic [DW-1:0] duty;
    } duty_st_t;

    duty_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ovr_nxt_i)     st_d.duty = req_i;
        else if (use_max_i) st_d.duty = max_i;
        else                st_d.duty = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign duty_o = st_q.duty;

    // R7: with no event the request passes through one cycle later
    assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_nxt_i |=> (duty_o == $past(req_i)));
    // R5: full duty boost
    assert_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_nxt_i && !use_max_i) |=> (&duty_o));
endmodule

// File: rtl/ot_therm_pin.sv
module ot_therm_pin
    import ot_pkg::*;
#(
    parameter int NZONE = 3,
    localparam int SELW = $clog2(NZONE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NZONE-1:0] above_i,
    input  logic [SELW-1:0]  sel_i,
    input  logic             latch_off_i,
    input  logic             ack_i,
    output logic             pin_o
);
    therm_st_t st_d, st_q;
    logic      cond;

    always_comb begin
        cond = 1'b0;
        for (int z = 0; z < NZONE; z++) begin
            if (int'(sel_i) == z) cond = above_i[z];
        end
        st_d     = st_q;
        st_d.pin = cond | (~latch_off_i & st_q.pin & ~ack_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_o = st_q.pin;

    // R10: a latched pin survives until acknowledged
    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_o && !latch_off_i && !ack_i) |=> pin_o);
    // R9: a selected zone above its limit raises the pin
    assert_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_i) < NZONE && (|(above_i & (NZONE'(1) << sel_i)))) |=> pin_o);
    // R11: in live mode the pin drops when the condition is absent
    assert_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_off_i && ((above_i & (NZONE'(1) << sel_i)) == '0)) |=> !pin_o);
endmodule

// File: rtl/ot_fan_override.sv
module ot_fan_override
    import ot_pkg::*;
#(
    parameter int NZONE = 3,
    parameter int NCH   = 3,
    parameter int LW    = 8,
    parameter int HW    = 8,
    parameter int DW    = 8,
    localparam int TW   = LW + FRAC_BITS,
    localparam int SELW = $clog2(NZONE + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NZONE-1:0][TW-1:0]  temp_i,
    input  logic [NZONE-1:0][LW-1:0]  lim_i,
    input  logic [NZONE-1:0][HW-1:0]  hyst_i,
    input  logic                      cfg_hold_off_i,
    input  logic                      cfg_use_max_i,
    input  logic [NCH-1:0][DW-1:0]    duty_max_i,
    input  logic [NCH-1:0][DW-1:0]    duty_req_i,
    input  logic [SELW-1:0]           therm_sel_i,
    input  logic                      cfg_latch_off_i,
    input  logic                      therm_ack_i,
    output logic [NCH-1:0][DW-1:0]    duty_o,
    output logic [NZONE-1:0]          ot_status_o,
    output logic                      therm_o
);
    logic [NZONE-1:0] above;
    logic [NZONE-1:0] act_nxt;
    logic             ovr_nxt;

    for (genvar z = 0; z < NZONE; z++) begin : g_zone
        ot_zone_track #(.LW(LW), .HW(HW)) u_zone (
            .clk        (clk),
            .rst_n      (rst_n),
            .temp_i     (temp_i[z]),
            .lim_i      (lim_i[z]),
            .hyst_i     (hyst_i[z]),
            .hold_off_i (cfg_hold_off_i),
            .above_o    (above[z]),
            .act_nxt_o  (act_nxt[z]),
            .act_o      (ot_status_o[z])
        );
    end

    assign ovr_nxt = |act_nxt;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ot_duty_sel #(.DW(DW)) u_duty (
            .clk       (clk),
            .rst_n     (rst_n),
            .ovr_nxt_i (ovr_nxt),
            .use_max_i (cfg_use_max_i),
            .max_i     (duty_max_i[c]),
            .req_i     (duty_req_i[c]),
            .duty_o    (duty_o[c])
        );
    end

    ot_therm_pin #(.NZONE(NZONE)) u_therm (
        .clk         (clk),
        .rst_n       (rst_n),
        .above_i     (above),
        .sel_i       (therm_sel_i),
        .latch_off_i (cfg_latch_off_i),
        .ack_i       (therm_ack_i),
        .pin_o       (therm_o)
    );

    // R6: a programmed-ceiling boost lands on every channel
    assert_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ot_status_o && $past(cfg_use_max_i)) |-> (duty_o == $past(duty_max_i)));
    // R8: status bits only change on the clock after an input sample
    assert_status_onehot_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_status_o == '0) |-> !$past(|act_nxt));
endmodule

// File: tb/tb_ot_fan_override.sv
module tb_ot_fan_override;
    localparam int NZONE = 3;
    localparam int NCH   = 3;
    localparam int LW    = 8;
    localparam int HW    = 8;
    localparam int DW    = 8;
    localparam int TW    = LW + 2;
    localparam int SELW  = 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NZONE-1:0][TW-1:0] temp;
    logic [NZONE-1:0][LW-1:0] lim;
    logic [NZONE-1:0][HW-1:0] hyst;
    logic                     hold_off, use_max, latch_off, ack;
    logic [NCH-1:0][DW-1:0]   dmax, dreq, duty;
    logic [SELW-1:0]          sel;
    logic [NZONE-1:0]         status;
    logic                     therm;

    int n_chk = 0;
    int n_fail = 0;
    logic [NZONE-1:0] m_act = '0;
    logic             m_therm = 1'b0;

    always #2 clk = ~clk;

    ot_fan_override dut (
        .clk(clk), .rst_n(rst_n), .temp_i(temp), .lim_i(lim), .hyst_i(hyst),
        .cfg_hold_off_i(hold_off), .cfg_use_max_i(use_max),
        .duty_max_i(dmax), .duty_req_i(dreq), .therm_sel_i(sel),
        .cfg_latch_off_i(latch_off), .therm_ack_i(ack),
        .duty_o(duty), .ot_status_o(status), .therm_o(therm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int clampt(input int t);
        if (t < 0) return 0;
        if (t > 1023) return 1023;
        return t;
    endfunction

    // One clock: model update at the edge, compare at the following falling edge.
    task automatic tick();
        logic [NZONE-1:0] ab;
        logic [NCH-1:0][DW-1:0] ed;
        @(posedge clk);
        for (int z = 0; z < NZONE; z++) begin
            int lq, hq, rel;
            logic drop;
            lq = int'(lim[z]) * 4;
            hq = int'(hyst[z]) * 4;
            rel = (hq > lq) ? 0 : lq - hq;
            ab[z] = int'(temp[z]) > lq;
            drop = hold_off ? (int'(temp[z]) < lq) : (int'(temp[z]) < rel);
            m_act[z] = ab[z] | (m_act[z] & ~drop);
        end
        for (int c = 0; c < NCH; c++)
            ed[c] = (|m_act) ? (use_max ? dmax[c] : 8'hFF) : dreq[c];
        m_therm = ((int'(sel) < NZONE) ? ab[sel] : 1'b0) | (~latch_off & m_therm & ~ack);
        @(negedge clk);
        chk("R8 status", 32'(status), 32'(m_act));
        for (int c = 0; c < NCH; c++)
            chk((|m_act) ? (use_max ? "R6 duty" : "R5 duty") : "R7 duty",
                32'(duty[c]), 32'(ed[c]));
        chk(latch_off ? "R11 therm" : "R10 therm", 32'(therm), 32'(m_therm));
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        temp = {10'd400, 10'd400, 10'd400};
        lim  = {8'd150, 8'd200, 8'd164};
        hyst = {8'd4, 8'd4, 8'd4};
        hold_off = 0; use_max = 0; latch_off = 0; ack = 0; sel = 2'd1;
        dmax = {8'hE0, 8'hD0, 8'hC0};
        dreq = {8'h66, 8'h55, 8'h40};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 status", 32'(status), 0);
        chk("R12 therm", 32'(therm), 0);
        chk("R12 duty", 32'(duty), 0);
        rst_n = 1'b1;
        tick();
        chk("R7 pass", 32'(duty[1]), 32'h55);

        temp[0] = 10'd656; tick();
        chk("R1 equal", 32'(status), 0);
        temp[0] = 10'd657;
        chk("R13 before edge", 32'(status), 0);
        tick();
        chk("R1 trip", 32'(status), 1);
        chk("R13 after edge", 32'(duty[0]), 32'hFF);
        chk("R5 full", 32'(duty[2]), 32'hFF);
        temp[0] = 10'd640; tick();
        chk("R2 hold", 32'(status), 1);
        temp[0] = 10'd639; tick();
        chk("R2 release", 32'(status), 0);
        chk("R7 back", 32'(duty[1]), 32'h55);

        hold_off = 1; temp[0] = 10'd657; tick();
        temp[0] = 10'd656; tick();
        chk("R3 at limit", 32'(status), 1);
        temp[0] = 10'd655; tick();
        chk("R3 release", 32'(status), 0);
        hold_off = 0;

        lim[2] = 8'd2; hyst[2] = 8'd10; temp[2] = 10'd9; tick();
        chk("R4 trip", 32'(status[2]), 1);
        temp[2] = 10'd0; tick(); tick();
        chk("R4 saturate", 32'(status[2]), 1);
        lim[2] = 8'd150; temp[2] = 10'd400; tick();
        chk("R8 clears", 32'(status[2]), 0);

        temp[0] = 10'd700; use_max = 1; tick();
        chk("R6 ch0", 32'(duty[0]), 32'hC0);
        chk("R6 ch2", 32'(duty[2]), 32'hE0);
        use_max = 0; tick();
        chk("R5 full", 32'(duty[1]), 32'hFF);
        temp[0] = 10'd400; tick();

        temp[1] = 10'd801; tick();
        chk("R9 raise", 32'(therm), 1);
        temp[1] = 10'd700; tick();
        chk("R10 latched", 32'(therm), 1);
        temp[1] = 10'd801; ack = 1; tick();
        chk("R10 ack ignored", 32'(therm), 1);
        temp[1] = 10'd700; tick();
        chk("R10 ack clears", 32'(therm), 0);
        ack = 0; latch_off = 1; temp[1] = 10'd801; tick();
        chk("R11 live on", 32'(therm), 1);
        temp[1] = 10'd700; tick();
        chk("R11 live off", 32'(therm), 0);
        latch_off = 0; sel = 2'd3; temp[1] = 10'd801; tick();
        chk("R9 none selected", 32'(therm), 0);
        temp[1] = 10'd400; sel = 2'd1; tick();

        for (int i = 0; i < 3000; i++) begin
            for (int z = 0; z < NZONE; z++)
                temp[z] = TW'(clampt(int'(lim[z]) * 4 + int'($urandom_range(0, 80)) - 40));
            if (i % 50 == 0) begin
                for (int z = 0; z < NZONE; z++) begin
                    hyst[z] = HW'($urandom_range(0, 12));
                    lim[z]  = LW'($urandom_range(0, 255));
                end
            end
            if ($urandom_range(0, 15) == 0) hold_off = ~hold_off;
            if ($urandom_range(0, 15) == 0) use_max = ~use_max;
            if ($urandom_range(0, 31) == 0) latch_off = ~latch_off;
            if ($urandom_range(0, 31) == 0) sel = SELW'($urandom_range(0, 3));
            ack = ($urandom_range(0, 7) == 0);
            for (int c = 0; c < NCH; c++) dreq[c] = DW'($urandom);
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule